// File: doc/BRIEF.md
# Disk Controller Data FIFO with Service Threshold

This block sits between the host data port of a floppy-style disk controller and the controller's byte stream toward the media. The host reads and writes a single data port. Two status outputs tell it when it may touch that port (`rqm`) and which way bytes are moving (`dio`). A service request (`svc_req`) is meant to drive a DMA channel or an interrupt. On the controller side there is one byte strobe (`ctl_stb`). What the strobe does depends on the phase: it takes command bytes away, carries disk bytes during a transfer, or delivers result bytes.

The block steps through command, execution and result phases. After reset, and at the start of every command, the store holds only one byte, as a legacy single-byte data register does. A configuration write can enable the full 16-entry FIFO with a threshold of 1 to 15 bytes. That setting takes effect at the next entry to execution, and the store is flushed on that entry. In the enabled mode the service request is timed so that the host keeps a window of `threshold` byte periods before the transfer fails.

A disk-side push into a full store is an overrun. A disk-side pop from an empty store is an underrun. Either one sets a sticky error and halts further transfer. After an underrun on a write, the disk side receives 0x00 bytes until the sector ends, and a one-cycle request to append the CRC is then raised. After an overrun on a read, the host must drain the store before the result phase begins.

Top module: `disk_data_fifo`

## Requirements
- R1: After reset, `phase` = 0 (command), `rqm` = 1, `dio` = 0, `svc_req` = 0, `xfer_err` = 0, and the FIFO is disabled. The phase encoding is 0 command, 1 execution, 2 result.
- R2: In the command phase, a host write fills a one-byte holding slot and drops `rqm`. A further host write while the slot is full is ignored. A `ctl_stb` removes the byte on `ctl_dout` and raises `rqm` again.
- R3: `exec_start` puts the block in phase 1, latches the direction (`xfer_read` = 1 means disk to host) and the configuration, and flushes every byte that is held.
- R4: With the FIFO enabled and threshold T in a read, `svc_req` rises when the occupancy reaches 16−T. The host then still has T byte periods before the store is full, and it reads bytes back in arrival order.
- R5: With the FIFO enabled and threshold T in a write, `svc_req` is high while the free entries are at least T. `ctl_dout` presents the host bytes in the order they were written.
- R6: With the FIFO disabled in execution, the store holds one byte. `svc_req` means one byte is ready in a read, or the slot is empty in a write.
- R7: A `ctl_stb` push while the store is full in a read sets `xfer_err`. That byte and all later disk bytes are dropped.
- R8: After an overrun, the phase stays 1 while bytes remain. It becomes 2 one cycle after the host's last read empties the store.
- R9: A `ctl_stb` pop while the store is empty in a write sets `xfer_err`. After that, host writes are ignored, `rqm` is 0 and `ctl_dout` is 0x00.
- R10: In a write with `xfer_err` set, `sector_end` moves the phase to 2 and raises `crc_req` for exactly one cycle.
- R11: `cmd_start` clears `xfer_err` and returns to phase 0, with the store flushed and holding one byte.
- R12: A configured threshold of 0 is treated as 1.
- R13: In the result phase, a `ctl_stb` pushes one result byte, and `dio` = 1. `rqm` is 1 while a byte waits, and a host read returns that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fifo_en | input | 1 | Enables the 16-entry FIFO for later transfers |
| cfg_thresh | input | 4 | Service threshold in bytes (0 treated as 1) |
| cmd_start | input | 1 | Pulse: a new command begins |
| exec_start | input | 1 | Pulse: the execution phase begins |
| exec_end | input | 1 | Pulse: normal end of the execution phase |
| xfer_read | input | 1 | Transfer direction, 1 = disk to host |
| host_wr | input | 1 | Host write to the data port |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read of the data port |
| host_rdata | output | 8 | Byte at the head of the store |
| rqm | output | 1 | Host may access the data port |
| dio | output | 1 | 1 = controller to host, 0 = host to controller |
| svc_req | output | 1 | DMA / interrupt service request |
| ctl_stb | input | 1 | Controller-side byte strobe |
| ctl_din | input | 8 | Byte pushed by the controller side |
| ctl_dout | output | 8 | Byte presented to the controller side |
| sector_end | input | 1 | Pulse: the current sector ends |
| crc_req | output | 1 | One-cycle request to append a CRC after padding |
| xfer_err | output | 1 | Sticky overrun/underrun flag |
| phase | output | 2 | Current phase: 0 command, 1 execution, 2 result |

## Verification
The hardest state to reach is the overrun drain. The store must first fill to exactly 16 at the disk byte period, and the host must stay silent the whole time. Only then does one more disk push become the error, with the drain of sixteen reads following it. The stimulus times disk pushes four cycles apart, counts them against the threshold, and samples `svc_req` at push 16−T. It then keeps pushing past full and checks that the phase holds through fifteen reads and moves only after the last one. The underrun case is reached by popping past the scoreboard's last expected byte, and the zero bytes and `crc_req` that follow are then checked.

// File: rtl/dfifo_pkg.sv
// Package: shared types for the disk data FIFO.
// Assumes: phase encoding is visible on the top-level port and fixed.
package dfifo_pkg;
    typedef enum logic [1:0] {
        PH_CMD    = 2'd0,
        PH_EXEC   = 2'd1,
        PH_RESULT = 2'd2
    } phase_t;
endpackage

// File: rtl/dfifo_store.sv
// Module: byte store with a run-time capacity limit.
// Does: circular buffer of DEPTH entries; push refused at capacity, pop
//       refused when empty; flush empties it in one cycle (flush wins).
// Assumes: DEPTH is a power of two; cap is between 1 and DEPTH.
module dfifo_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] cap,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          wr_en, rd_en;

    assign full  = (count >= cap);
    assign empty = (count == '0);
    assign wr_en = push && !full && !flush;
    assign rd_en = pop && !empty && !flush;
    assign dout  = mem[rd_ptr];

    // Writes the incoming byte into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= din;
    end

    // Moves the pointers and occupancy, or clears them on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_flush_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
endmodule

// File: rtl/dfifo_ctrl.sv
// Module: phase sequencer and error tracker.
// Does: holds configuration, steps command/execution/result, detects
//       overrun and underrun, decides when an errored transfer may finish
//       and issues the flush and CRC-append pulses.
// Assumes: cmd_start and exec_start are single-cycle pulses.
module dfifo_ctrl
    import dfifo_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_fifo_en,
    input  logic [TW-1:0] cfg_thresh,
    input  logic          cmd_start,
    input  logic          exec_start,
    input  logic          exec_end,
    input  logic          xfer_read,
    input  logic          sector_end,
    input  logic          ctl_stb,
    input  logic          full,
    input  logic          empty,
    output phase_t        phase,
    output logic          err,
    output logic          rd_dir,
    output logic          fifo_on,
    output logic [TW-1:0] thr,
    output logic          flush,
    output logic          crc_req
);
    logic          cfg_en_q, en_l;
    logic [TW-1:0] cfg_thr_q;
    logic          in_exec, ovr, udr, pad_done, drain_done, to_result;

    assign in_exec    = (phase == PH_EXEC);
    assign ovr        = in_exec && rd_dir && ctl_stb && full && !err;
    assign udr        = in_exec && !rd_dir && ctl_stb && empty && !err;
    assign pad_done   = err && !rd_dir && sector_end;
    assign drain_done = err && rd_dir && empty;
    assign to_result  = in_exec && !cmd_start && !exec_start &&
                        (pad_done || drain_done || (!err && exec_end));
    assign flush      = cmd_start || exec_start || to_result;
    assign fifo_on    = in_exec && en_l;

    // Captures configuration writes; a zero threshold becomes one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en_q  <= 1'b0;
            cfg_thr_q <= TW'(1);
        end else if (cfg_we) begin
            cfg_en_q  <= cfg_fifo_en;
            cfg_thr_q <= (cfg_thresh == '0) ? TW'(1) : cfg_thresh;
        end
    end

    // Advances the phase, latches transfer settings and tracks the error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_CMD;
            err     <= 1'b0;
            rd_dir  <= 1'b0;
            en_l    <= 1'b0;
            thr     <= TW'(1);
            crc_req <= 1'b0;
        end else begin
            crc_req <= 1'b0;
            if (cmd_start) begin
                phase <= PH_CMD;
                err   <= 1'b0;
                en_l  <= 1'b0;
            end else if (exec_start) begin
                phase  <= PH_EXEC;
                rd_dir <= xfer_read;
                en_l   <= cfg_en_q;
                thr    <= cfg_thr_q;
            end else if (in_exec) begin
                if (ovr || udr) err <= 1'b1;
                if (to_result) begin
                    phase   <= PH_RESULT;
                    crc_req <= pad_done;
                end
            end
        end
    end

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !cmd_start) |=> err);
    p_cmd_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (!err && phase == PH_CMD));
    p_crc_in_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        crc_req |-> (phase == PH_RESULT));
endmodule

// File: rtl/dfifo_req.sv
// Module: host handshake and service-request generator.
// Does: derives rqm, dio and svc_req from phase, direction, mode,
//       threshold, error and occupancy.
// Assumes: thr is already between 1 and DEPTH-1.
module dfifo_req
    import dfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TW    = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  phase_t        phase,
    input  logic          rd_dir,
    input  logic          fifo_on,
    input  logic [TW-1:0] thr,
    input  logic          err,
    input  logic [CW-1:0] count,
    input  logic          full,
    input  logic          empty,
    output logic          blk,
    output logic          rqm,
    output logic          dio,
    output logic          svc_req
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    logic [CW-1:0] thr_w, free_w;

    assign thr_w  = CW'(thr);
    assign free_w = DEPTH_C - count;

    // Direction, access permission and transfer block for the host side.
    always_comb begin
        dio = (phase == PH_RESULT) || (phase == PH_EXEC && rd_dir);
        blk = err && (phase == PH_EXEC);
        rqm = dio ? !empty : (!full && !blk);
    end

    // Service request: threshold-driven when enabled, per byte otherwise.
    always_comb begin
        if (phase != PH_EXEC)
            svc_req = 1'b0;
        else if (err)
            svc_req = rd_dir && !empty;
        else if (rd_dir)
            svc_req = fifo_on ? (count >= DEPTH_C - thr_w) : !empty;
        else
            svc_req = fifo_on ? (free_w >= thr_w) : empty;
    end
endmodule

// File: rtl/disk_data_fifo.sv
// Module: top of the disk controller data FIFO.
// Does: routes host and controller-side strobes into the store according
//       to phase and direction, pads with zeros after a write underrun.
// Assumes: the host never writes and reads in the same cycle.
module disk_data_fifo
    import dfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int TW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_fifo_en,
    input  logic [TW-1:0] cfg_thresh,
    input  logic          cmd_start,
    input  logic          exec_start,
    input  logic          exec_end,
    input  logic          xfer_read,
    input  logic          host_wr,
    input  logic [W-1:0]  host_wdata,
    input  logic          host_rd,
    output logic [W-1:0]  host_rdata,
    output logic          rqm,
    output logic          dio,
    output logic          svc_req,
    input  logic          ctl_stb,
    input  logic [W-1:0]  ctl_din,
    output logic [W-1:0]  ctl_dout,
    input  logic          sector_end,
    output logic          crc_req,
    output logic          xfer_err,
    output logic [1:0]    phase
);
    localparam int CW = $clog2(DEPTH + 1);

    phase_t        ph;
    logic          err, rd_dir, fifo_on, flush, blk, full, empty;
    logic          push, pop;
    logic [TW-1:0] thr;
    logic [CW-1:0] count, cap;
    logic [W-1:0]  din, head;

    // Routes strobes: the side named by dio as the source pushes, the other pops.
    always_comb begin
        cap  = fifo_on ? CW'(DEPTH) : CW'(1);
        push = dio ? (ctl_stb && !blk) : (host_wr && !blk);
        pop  = dio ? host_rd : (ctl_stb && !blk);
        din  = dio ? ctl_din : host_wdata;
    end

    assign host_rdata = head;
    assign ctl_dout   = (blk && !rd_dir) ? '0 : head;
    assign xfer_err   = err;
    assign phase      = ph;

    dfifo_ctrl #(.TW(TW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_fifo_en(cfg_fifo_en),
        .cfg_thresh(cfg_thresh), .cmd_start(cmd_start), .exec_start(exec_start),
        .exec_end(exec_end), .xfer_read(xfer_read), .sector_end(sector_end),
        .ctl_stb(ctl_stb), .full(full), .empty(empty), .phase(ph), .err(err),
        .rd_dir(rd_dir), .fifo_on(fifo_on), .thr(thr), .flush(flush),
        .crc_req(crc_req)
    );

    dfifo_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
        .din(din), .cap(cap), .dout(head), .count(count), .full(full),
        .empty(empty)
    );

    dfifo_req #(.DEPTH(DEPTH), .TW(TW)) u_req (
        .phase(ph), .rd_dir(rd_dir), .fifo_on(fifo_on), .thr(thr), .err(err),
        .count(count), .full(full), .empty(empty), .blk(blk), .rqm(rqm),
        .dio(dio), .svc_req(svc_req)
    );

    p_cmd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_CMD) |-> (count <= CW'(1)));
    p_drain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_EXEC && rd_dir && err && !empty && !cmd_start && !exec_start)
        |=> (ph == PH_EXEC));
    p_no_fill_after_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_EXEC && rd_dir && err) |=> (count <= $past(count)));
endmodule

// File: tb/sim_disk_data_fifo.sv
module sim_disk_data_fifo;
    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 0, cfg_fifo_en = 0;
    logic [3:0] cfg_thresh = 4'd1;
    logic       cmd_start = 0, exec_start = 0, exec_end = 0, xfer_read = 0;
    logic       host_wr = 0, host_rd = 0, ctl_stb = 0, sector_end = 0;
    logic [7:0] host_wdata = 0, ctl_din = 0;
    logic [7:0] host_rdata, ctl_dout;
    logic       rqm, dio, svc_req, crc_req, xfer_err;
    logic [1:0] phase;

    int checks = 0, fails = 0;
    bit done = 0, mon_host = 0, mon_ctl = 0;
    logic [7:0] q[$];
    logic [7:0] mon_e;

    always #10 clk = ~clk;

    disk_data_fifo u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_fifo_en(cfg_fifo_en),
        .cfg_thresh(cfg_thresh), .cmd_start(cmd_start), .exec_start(exec_start),
        .exec_end(exec_end), .xfer_read(xfer_read), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .rqm(rqm), .dio(dio), .svc_req(svc_req), .ctl_stb(ctl_stb),
        .ctl_din(ctl_din), .ctl_dout(ctl_dout), .sector_end(sector_end),
        .crc_req(crc_req), .xfer_err(xfer_err), .phase(phase)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #2;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    // Driver tasks: accepted bytes go into the scoreboard queue.
    task automatic host_write(logic [7:0] b, bit acc);
        host_wr = 1; host_wdata = b;
        if (acc) q.push_back(b);
        cyc();
        host_wr = 0;
    endtask

    task automatic host_read();
        host_rd = 1; mon_host = 1;
        cyc();
        host_rd = 0; mon_host = 0;
    endtask

    task automatic ctl_push(logic [7:0] b, bit acc);
        ctl_stb = 1; ctl_din = b;
        if (acc) q.push_back(b);
        cyc();
        ctl_stb = 0;
    endtask

    task automatic ctl_pop();
        ctl_stb = 1; mon_ctl = 1;
        cyc();
        ctl_stb = 0; mon_ctl = 0;
    endtask

    task automatic ctl_pad();
        ctl_stb = 1;
        cyc();
        ctl_stb = 0;
    endtask

    task automatic configure(bit en, logic [3:0] t);
        cfg_we = 1; cfg_fifo_en = en; cfg_thresh = t;
        cyc();
        cfg_we = 0;
    endtask

    task automatic new_cmd();
        cmd_start = 1; cyc(); cmd_start = 0;
        q.delete();
    endtask

    task automatic start_exec(bit rd);
        xfer_read = rd; exec_start = 1; cyc(); exec_start = 0;
        q.delete();
    endtask

    // Monitor: compares each byte the design hands out with the queue head.
    always @(negedge clk) begin
        if (mon_host) begin
            if (q.size() == 0) chk(0, "R4 host read with no expected byte", host_rdata, 0);
            else begin
                mon_e = q.pop_front();
                chk(host_rdata == mon_e, "R4 host read order", host_rdata, mon_e);
            end
        end
        if (mon_ctl) begin
            if (q.size() == 0) chk(0, "R5 ctl pop with no expected byte", ctl_dout, 0);
            else begin
                mon_e = q.pop_front();
                chk(ctl_dout == mon_e, "R5 ctl pop order", ctl_dout, mon_e);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        cyc();
        // R1 reset state
        chk(phase == 2'd0, "R1 phase", phase, 0);
        chk(rqm == 1, "R1 rqm", rqm, 1);
        chk(dio == 0, "R1 dio", dio, 0);
        chk(svc_req == 0, "R1 svc_req", svc_req, 0);
        chk(xfer_err == 0, "R1 xfer_err", xfer_err, 0);

        // R2 command phase single byte
        host_write(8'hA5, 1);
        chk(rqm == 0, "R2 rqm after write", rqm, 0);
        host_write(8'h11, 0);
        chk(ctl_dout == 8'hA5, "R2 second write ignored", ctl_dout, 8'hA5);
        ctl_pop();
        chk(rqm == 1, "R2 rqm after take", rqm, 1);

        // R3 flush on exec entry; R6 disabled read
        host_write(8'h22, 1);
        start_exec(1);
        chk(phase == 2'd1, "R3 phase exec", phase, 1);
        chk(dio == 1 && rqm == 0, "R3 flushed empty", {dio, rqm}, 2'b10);
        ctl_push(8'h31, 1);
        chk(svc_req == 1 && rqm == 1, "R6 single byte ready", {svc_req, rqm}, 2'b11);
        host_read();
        chk(svc_req == 0, "R6 svc drops after read", svc_req, 0);
        exec_end = 1; cyc(); exec_end = 0;
        // R13 result phase
        chk(phase == 2'd2 && dio == 1 && rqm == 0, "R13 result idle",
            {phase, dio, rqm}, 4'b1010);
        ctl_push(8'h7E, 1);
        chk(rqm == 1, "R13 result byte waiting", rqm, 1);
        host_read();
        chk(rqm == 0, "R13 result byte taken", rqm, 0);

        // R4 enabled read, threshold 4; R7 overrun; R8 drain
        configure(1, 4'd4);
        new_cmd();
        start_exec(1);
        for (int i = 1; i <= 16; i++) begin
            ctl_push(8'h40 + 8'(i), 1);
            if (i == 11) chk(svc_req == 0, "R4 svc low below 16-T", svc_req, 0);
            if (i == 12) chk(svc_req == 1, "R4 svc at 16-T", svc_req, 1);
            idle(P - 1);
        end
        chk(xfer_err == 0, "R4 T byte periods of window after svc", xfer_err, 0);
        ctl_push(8'hEE, 0);
        chk(xfer_err == 1, "R7 overrun sets error", xfer_err, 1);
        ctl_push(8'hEF, 0);
        for (int i = 0; i < 15; i++) host_read();
        chk(phase == 2'd1, "R8 phase held while bytes remain", phase, 1);
        host_read();
        cyc();
        chk(phase == 2'd2, "R8 result after drain", phase, 2);
        chk(q.size() == 0, "R7 dropped bytes never seen", q.size(), 0);

        // R11 new command clears error
        new_cmd();
        chk(xfer_err == 0 && phase == 2'd0, "R11 error cleared", {xfer_err, phase}, 0);
        host_write(8'h5A, 1);
        chk(rqm == 0, "R11 single byte in command", rqm, 0);

        // R5 enabled write, threshold 8; R9 underrun; R10 pad end
        configure(1, 4'd8);
        start_exec(0);
        chk(svc_req == 1 && dio == 0, "R5 svc with empty store", {svc_req, dio}, 2'b10);
        for (int i = 1; i <= 9; i++) begin
            host_write(8'h80 + 8'(i), 1);
            if (i == 8) chk(svc_req == 1, "R5 svc at free=T", svc_req, 1);
        end
        chk(svc_req == 0, "R5 svc low at free<T", svc_req, 0);
        ctl_pop();
        chk(svc_req == 1, "R5 svc back at free=T", svc_req, 1);
        for (int i = 0; i < 8; i++) begin
            ctl_pop();
            idle(P - 1);
        end
        ctl_pad();
        chk(xfer_err == 1, "R9 underrun sets error", xfer_err, 1);
        chk(ctl_dout == 8'h00, "R9 pad byte zero", ctl_dout, 0);
        chk(rqm == 0, "R9 rqm low after underrun", rqm, 0);
        host_write(8'h55, 0);
        ctl_pad();
        chk(ctl_dout == 8'h00, "R9 host write ignored, pad stays zero", ctl_dout, 0);
        sector_end = 1; cyc(); sector_end = 0;
        chk(crc_req == 1 && phase == 2'd2, "R10 crc request at sector end",
            {crc_req, phase}, 3'b110);
        cyc();
        chk(crc_req == 0, "R10 crc request one cycle", crc_req, 0);

        // R12 threshold 0 acts as 1
        configure(1, 4'd0);
        new_cmd();
        start_exec(1);
        for (int i = 1; i <= 15; i++) begin
            ctl_push(8'(i), 1);
            if (i == 14) chk(svc_req == 0, "R12 svc low at 14", svc_req, 0);
        end
        chk(svc_req == 1, "R12 svc at 15", svc_req, 1);

        // R6 disabled write
        configure(0, 4'd4);
        new_cmd();
        start_exec(0);
        chk(svc_req == 1, "R6 write slot empty", svc_req, 1);
        host_write(8'h66, 1);
        chk(svc_req == 0 && rqm == 0, "R6 write slot full", {svc_req, rqm}, 0);
        ctl_pop();
        chk(svc_req == 1, "R6 slot empty again", svc_req, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule